// File: doc/BRIEF.md
# Lockable Watchdog Timer with Debug Halt

This block is a watchdog timer with two registers on a simple 32-bit register bus: a control register and a service register. The control register holds a six-bit time-out value, an enable bit, and three halt enables: one for debug, one for stop mode and one for doze mode. After reset the control register can be written once. A debug-mode input lifts that lock, so a debugger can rewrite the control bits as often as it needs. Values written this way stay in force after debug mode ends.

A six-bit down counter advances once per pulse of a tick-enable input. It is loaded from the time-out field when the watchdog becomes enabled and each time software completes the service sequence. The service sequence is two writes to the service register: first 0x5555, then 0xAAAA. When the count expires while the watchdog is enabled, a reset-request output pulses high for one clock and the counter reloads. Whenever a low-power or debug input is high and its matching halt enable is set, the counter holds its value. Register access keeps working during such a hold.

Top module: `wdog_lockable`

## Requirements
- R1: After synchronous reset the control register reads 0x00000000 and `wdt_rst_req` is low.
- R2: The control register is at byte offset 0x0 and the service register at offset 0x4. The control register image is: bit 0 enable, bit 1 debug halt, bit 2 doze halt, bit 3 stop halt, bits 13:8 time-out, and every other bit reads zero. The control register responds only to accesses with `bus_size` = 2 (32-bit). A write with `bus_size` 0 (byte) or 1 (halfword) leaves it unchanged, and a read with those sizes returns zero.
- R3: While `dbg_mode` is low, only the first accepted control write after reset takes effect. Every later control write leaves the register unchanged.
- R4: While `dbg_mode` is high, every 32-bit control write takes effect, however many there are. The values written stay in force after `dbg_mode` falls, and the lock then still applies.
- R5: Writing 0x00005555 and then 0x0000AAAA to the service register reloads the counter from the time-out field.
- R6: Any other value written to the service register after 0x00005555 and before 0x0000AAAA cancels the sequence, and the following 0x0000AAAA does not reload the counter.
- R7: A control write that changes the enable bit from 0 to 1 loads the counter from the time-out value in that same write.
- R8: While enabled and not halted, each `tick_en` pulse is a counted tick. With time-out T ≥ 1, the T-th counted tick after a load makes `wdt_rst_req` high for exactly the following clock and reloads the counter. A time-out of 0 behaves as 1. While the watchdog is disabled, ticks have no effect.
- R9: While `dbg_mode` is high and the debug-halt bit is set, ticks do not advance the counter, but register writes and reads still take effect.
- R10: While `stop_mode` is high with the stop-halt bit set, or while `doze_mode` is high with the doze-halt bit set, ticks do not advance the counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Byte offset of the register |
| bus_size | input | 2 | Access size: 0 byte, 1 halfword, 2 word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data (combinational) |
| tick_en | input | 1 | Count-enable pulse |
| dbg_mode | input | 1 | Debug mode indication |
| stop_mode | input | 1 | Stop low-power mode indication |
| doze_mode | input | 1 | Doze low-power mode indication |
| wdt_rst_req | output | 1 | One-clock time-out reset request |

## Verification
The hardest situation to reach is a control value changed after the lock has closed. Reaching it takes the debug input: the write lock lifts, the bits are rewritten, and the counter is frozen by the debug-halt bit while the service register still reloads it. The stimulus locks the register with an ordinary first write. It then raises `dbg_mode`, rewrites the control register several times, and confirms the frozen count by ticking with no reset request. After dropping `dbg_mode` it shows that the new time-out governs the next expiry and that a plain write is refused again. To isolate the enable-rise load, the watchdog is disabled in debug and re-enabled with a time-out different from the count left behind, so that a load from the wrong value would show up as an expiry on the wrong tick.

// File: rtl/wdog_lockable_pkg.sv
package wdog_lockable_pkg;

    localparam int unsigned TO_W   = 6;
    localparam int unsigned REG_W  = 32;
    localparam int unsigned TO_LSB = 8;
    localparam int unsigned EN_BIT = 0;
    localparam int unsigned DH_BIT = 1;
    localparam int unsigned DZ_BIT = 2;
    localparam int unsigned ST_BIT = 3;

    localparam logic [REG_W-1:0] KEY_ARM  = REG_W'(32'h0000_5555);
    localparam logic [REG_W-1:0] KEY_FIRE = REG_W'(32'h0000_AAAA);

    typedef enum logic [1:0] {
        ACC_BYTE = 2'd0,
        ACC_HALF = 2'd1,
        ACC_WORD = 2'd2,
        ACC_RSVD = 2'd3
    } acc_size_e;

    typedef enum logic {
        SVC_IDLE  = 1'b0,
        SVC_ARMED = 1'b1
    } svc_state_e;

    typedef struct packed {
        logic [TO_W-1:0] timeout;
        logic            stop_halt;
        logic            doze_halt;
        logic            dbg_halt;
        logic            enable;
    } ctrl_t;

    function automatic logic [REG_W-1:0] ctrl_to_word(ctrl_t c);
        logic [REG_W-1:0] w;
        w                 = '0;
        w[EN_BIT]         = c.enable;
        w[DH_BIT]         = c.dbg_halt;
        w[DZ_BIT]         = c.doze_halt;
        w[ST_BIT]         = c.stop_halt;
        w[TO_LSB +: TO_W] = c.timeout;
        return w;
    endfunction

    function automatic ctrl_t word_to_ctrl(logic [REG_W-1:0] w);
        ctrl_t c;
        c.enable    = w[EN_BIT];
        c.dbg_halt  = w[DH_BIT];
        c.doze_halt = w[DZ_BIT];
        c.stop_halt = w[ST_BIT];
        c.timeout   = w[TO_LSB +: TO_W];
        return c;
    endfunction

    function automatic logic ctrl_halts(ctrl_t c, logic dbg, logic stop, logic doze);
        return (dbg && c.dbg_halt) || (stop && c.stop_halt) || (doze && c.doze_halt);
    endfunction

endpackage

// File: rtl/wdog_ctrl_reg.sv
module wdog_ctrl_reg
    import wdog_lockable_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic             dbg_mode,
    input  logic [REG_W-1:0] wdata,
    output ctrl_t            ctrl_q,
    output logic             en_rise,
    output logic [TO_W-1:0]  ld_timeout
);

    logic  locked_q;
    logic  accept;
    ctrl_t ctrl_nxt;

    assign ctrl_nxt   = word_to_ctrl(wdata);
    assign accept     = wr_en && (dbg_mode || !locked_q);
    assign en_rise    = accept && ctrl_nxt.enable && !ctrl_q.enable;
    assign ld_timeout = accept ? ctrl_nxt.timeout : ctrl_q.timeout;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q   <= '0;
            locked_q <= 1'b0;
        end else if (accept) begin
            ctrl_q   <= ctrl_nxt;
            locked_q <= 1'b1;
        end
    end

    // R1: control register is cleared by reset
    a_r1_ctrl_reset: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (ctrl_q == '0));

    // R3: once locked, a write outside debug leaves the register alone
    a_r3_lock_holds: assert property (@(posedge clk) disable iff (rst)
        (locked_q && !dbg_mode && wr_en) |=> $stable(ctrl_q));

    // R4: every write in debug mode lands
    a_r4_dbg_write_lands: assert property (@(posedge clk) disable iff (rst)
        (dbg_mode && wr_en) |=> (ctrl_q == word_to_ctrl($past(wdata))));

endmodule

// File: rtl/wdog_svc_seq.sv
module wdog_svc_seq
    import wdog_lockable_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wdata,
    output logic             svc_done
);

    svc_state_e state_q;
    svc_state_e state_d;

    assign svc_done = wr_en && (state_q == SVC_ARMED) && (wdata == KEY_FIRE);

    always_comb begin
        state_d = state_q;
        if (wr_en) begin
            if (wdata == KEY_ARM) begin
                state_d = SVC_ARMED;
            end else begin
                state_d = SVC_IDLE;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SVC_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // R5: a completed sequence returns the detector to idle
    a_r5_done_returns_idle: assert property (@(posedge clk) disable iff (rst)
        svc_done |=> (state_q == SVC_IDLE));

    // R6: a non-key write always cancels an armed sequence
    a_r6_other_cancels: assert property (@(posedge clk) disable iff (rst)
        (wr_en && (wdata != KEY_ARM)) |=> (state_q == SVC_IDLE));

endmodule

// File: rtl/wdog_down_counter.sv
module wdog_down_counter
    import wdog_lockable_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            enable,
    input  logic            halt,
    input  logic            tick_en,
    input  logic            en_rise,
    input  logic            svc_done,
    input  logic [TO_W-1:0] ld_timeout,
    output logic            expire_q
);

    localparam logic [TO_W-1:0] ONE = TO_W'(1);

    logic [TO_W-1:0] cnt_q;
    logic            counted;
    logic            at_end;

    assign counted = enable && tick_en && !halt;
    assign at_end  = (cnt_q <= ONE);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q    <= '0;
            expire_q <= 1'b0;
        end else begin
            expire_q <= 1'b0;
            if (en_rise || svc_done) begin
                cnt_q <= ld_timeout;
            end else if (counted) begin
                if (at_end) begin
                    expire_q <= 1'b1;
                    cnt_q    <= ld_timeout;
                end else begin
                    cnt_q <= cnt_q - ONE;
                end
            end
        end
    end

    // R9 R10: a halted counter keeps its value unless reloaded
    a_r9_halt_freezes: assert property (@(posedge clk) disable iff (rst)
        (halt && !svc_done && !en_rise) |=> (cnt_q == $past(cnt_q)));

    // R5: service reloads from the time-out field
    a_r5_svc_reload: assert property (@(posedge clk) disable iff (rst)
        svc_done |=> (cnt_q == $past(ld_timeout)));

    // R7: enable rise loads the newly written time-out
    a_r7_enable_load: assert property (@(posedge clk) disable iff (rst)
        en_rise |=> (cnt_q == $past(ld_timeout)));

    // R8: a request only follows a cycle in which the watchdog was enabled
    a_r8_req_needs_enable: assert property (@(posedge clk) disable iff (rst)
        expire_q |-> $past(enable));

endmodule

// File: rtl/wdog_lockable.sv
module wdog_lockable
    import wdog_lockable_pkg::*;
#(
    parameter int unsigned ADDR_W   = 4,
    parameter int unsigned CTRL_OFS = 0,
    parameter int unsigned SVC_OFS  = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [1:0]        bus_size,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic              tick_en,
    input  logic              dbg_mode,
    input  logic              stop_mode,
    input  logic              doze_mode,
    output logic              wdt_rst_req
);

    localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(CTRL_OFS);
    localparam logic [ADDR_W-1:0] SVC_A  = ADDR_W'(SVC_OFS);

    acc_size_e       acc;
    logic            hit_ctrl;
    logic            hit_svc;
    logic            ctrl_wr;
    logic            svc_wr;
    ctrl_t           ctrl_q;
    logic            en_rise;
    logic [TO_W-1:0] ld_timeout;
    logic            svc_done;
    logic            halt;

    assign acc      = acc_size_e'(bus_size);
    assign hit_ctrl = bus_sel && (bus_addr == CTRL_A) && (acc == ACC_WORD);
    assign hit_svc  = bus_sel && (bus_addr == SVC_A);
    assign ctrl_wr  = hit_ctrl && bus_wr;
    assign svc_wr   = hit_svc && bus_wr;
    assign halt     = ctrl_halts(ctrl_q, dbg_mode, stop_mode, doze_mode);

    always_comb begin
        bus_rdata = '0;
        if (hit_ctrl && !bus_wr) begin
            bus_rdata = ctrl_to_word(ctrl_q);
        end
    end

    wdog_ctrl_reg u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (ctrl_wr),
        .dbg_mode   (dbg_mode),
        .wdata      (bus_wdata),
        .ctrl_q     (ctrl_q),
        .en_rise    (en_rise),
        .ld_timeout (ld_timeout)
    );

    wdog_svc_seq u_svc (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (svc_wr),
        .wdata    (bus_wdata),
        .svc_done (svc_done)
    );

    wdog_down_counter u_cnt (
        .clk        (clk),
        .rst        (rst),
        .enable     (ctrl_q.enable),
        .halt       (halt),
        .tick_en    (tick_en),
        .en_rise    (en_rise),
        .svc_done   (svc_done),
        .ld_timeout (ld_timeout),
        .expire_q   (wdt_rst_req)
    );

    // R2: narrow reads of any register return zero
    a_r2_narrow_read_zero: assert property (@(posedge clk) disable iff (rst)
        (bus_sel && !bus_wr && (bus_size != 2'd2)) |-> (bus_rdata == '0));

    // R2: a narrow write never alters the control register
    a_r2_narrow_write_ignored: assert property (@(posedge clk) disable iff (rst)
        (bus_sel && bus_wr && (bus_size != 2'd2)) |=> $stable(ctrl_q));

    // R1: no reset request in the first cycle after reset
    a_r1_req_low_after_reset: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !wdt_rst_req);

endmodule

// File: tb/wdog_lockable_tb.sv
`timescale 1ns/1ps
module wdog_lockable_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [1:0]  bus_size = 2'd2;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        tick_en = 1'b0;
    logic        dbg_mode = 1'b0;
    logic        stop_mode = 1'b0;
    logic        doze_mode = 1'b0;
    logic        wdt_rst_req;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit done = 1'b0;
    int exp_q[$];

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    wdog_lockable u_dut (
        .clk         (clk),
        .rst         (rst),
        .bus_sel     (bus_sel),
        .bus_wr      (bus_wr),
        .bus_addr    (bus_addr),
        .bus_size    (bus_size),
        .bus_wdata   (bus_wdata),
        .bus_rdata   (bus_rdata),
        .tick_en     (tick_en),
        .dbg_mode    (dbg_mode),
        .stop_mode   (stop_mode),
        .doze_mode   (doze_mode),
        .wdt_rst_req (wdt_rst_req)
    );

    function automatic logic [31:0] img(int to, bit en, bit dh, bit dz, bit st);
        logic [31:0] w;
        w       = '0;
        w[0]    = en;
        w[1]    = dh;
        w[2]    = dz;
        w[3]    = st;
        w[13:8] = to[5:0];
        return w;
    endfunction

    task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, expv);
        end
    endtask

    // Scoreboard monitor: pops expected request cycles
    always @(negedge clk) begin
        if (!rst && !done) begin
            if (exp_q.size() > 0 && exp_q[0] < cyc) begin
                checks++;
                errors++;
                $display("FAIL R8 missing request actual=0 expected cycle %0d", exp_q[0]);
                void'(exp_q.pop_front());
            end
            if (wdt_rst_req) begin
                checks++;
                if (exp_q.size() > 0 && exp_q[0] == cyc) begin
                    void'(exp_q.pop_front());
                end else begin
                    errors++;
                    $display("FAIL R8 unexpected request actual=1 expected=0 cycle %0d", cyc);
                end
            end
        end
    end

    task automatic bus_write(logic [3:0] a, logic [1:0] sz, logic [31:0] d);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_size = sz; bus_wdata = d;
        @(posedge clk);
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic read_chk(logic [3:0] a, logic [1:0] sz, logic [31:0] expv, string req);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a; bus_size = sz;
        #1;
        chk(bus_rdata == expv, req, bus_rdata, expv);
        bus_sel = 1'b0;
        @(negedge clk);
    endtask

    task automatic tick(bit fire, string req);
        tick_en = 1'b1;
        @(posedge clk);
        #1;
        if (fire) exp_q.push_back(cyc);
        chk(wdt_rst_req == fire, req, {31'b0, wdt_rst_req}, {31'b0, fire});
        @(negedge clk);
        tick_en = 1'b0;
    endtask

    task automatic service();
        bus_write(4'h4, 2'd2, 32'h0000_5555);
        bus_write(4'h4, 2'd2, 32'h0000_AAAA);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=hung expected=finish");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        read_chk(4'h0, 2'd2, 32'h0, "R1 ctrl after reset");
        chk(wdt_rst_req == 1'b0, "R1 request low", {31'b0, wdt_rst_req}, 32'h0);

        // R2 R7 first write: time-out 3, enabled
        bus_write(4'h0, 2'd2, img(3, 1, 0, 0, 0));
        read_chk(4'h0, 2'd2, img(3, 1, 0, 0, 0), "R2 ctrl readback");
        read_chk(4'h0, 2'd1, 32'h0, "R2 narrow read zero");
        // R8 expiry on third tick
        tick(0, "R8 tick1");
        tick(0, "R8 tick2");
        tick(1, "R8 tick3 expires");
        @(negedge clk);
        chk(wdt_rst_req == 1'b0, "R8 single-cycle pulse", {31'b0, wdt_rst_req}, 32'h0);

        // R3 lock: second write ignored
        bus_write(4'h0, 2'd2, img(9, 1, 1, 1, 1));
        read_chk(4'h0, 2'd2, img(3, 1, 0, 0, 0), "R3 locked write ignored");

        // R5 service reload
        tick(0, "R5 pre tick1");
        tick(0, "R5 pre tick2");
        service();
        tick(0, "R5 post tick1");
        tick(0, "R5 post tick2");
        tick(1, "R5 post tick3 expires");

        // R6 broken sequence
        tick(0, "R6 tick1");
        bus_write(4'h4, 2'd2, 32'h0000_5555);
        bus_write(4'h4, 2'd2, 32'h0000_1234);
        bus_write(4'h4, 2'd2, 32'h0000_AAAA);
        tick(0, "R6 tick2");
        tick(1, "R6 no reload so expires");

        // R4 R9 debug rewrite and halt
        dbg_mode = 1'b1;
        bus_write(4'h0, 2'd2, img(4, 1, 1, 0, 0));
        read_chk(4'h0, 2'd2, img(4, 1, 1, 0, 0), "R4 debug write one");
        service();
        for (int i = 0; i < 6; i++) tick(0, "R9 halted in debug");
        bus_write(4'h0, 2'd2, img(2, 1, 1, 0, 0));
        read_chk(4'h0, 2'd2, img(2, 1, 1, 0, 0), "R4 debug write two");
        service();
        dbg_mode = 1'b0;
        tick(0, "R4 new time-out tick1");
        tick(1, "R4 new time-out expires");
        bus_write(4'h0, 2'd2, img(7, 0, 0, 0, 0));
        read_chk(4'h0, 2'd2, img(2, 1, 1, 0, 0), "R4 kept and relocked");

        // R10 stop and doze halts
        dbg_mode = 1'b1;
        bus_write(4'h0, 2'd2, img(2, 1, 0, 1, 1));
        service();
        dbg_mode = 1'b0;
        stop_mode = 1'b1;
        for (int i = 0; i < 3; i++) tick(0, "R10 stop halt");
        stop_mode = 1'b0;
        doze_mode = 1'b1;
        for (int i = 0; i < 3; i++) tick(0, "R10 doze halt");
        doze_mode = 1'b0;
        tick(0, "R10 resume tick1");
        tick(1, "R10 resume expires");

        // R2 narrow write in debug ignored
        dbg_mode = 1'b1;
        bus_write(4'h0, 2'd1, img(5, 0, 1, 0, 0));
        read_chk(4'h0, 2'd2, img(2, 1, 0, 1, 1), "R2 narrow write ignored");

        // R7 R8 disable, then enable loads new time-out
        bus_write(4'h0, 2'd2, img(1, 0, 0, 0, 0));
        for (int i = 0; i < 3; i++) tick(0, "R8 disabled no count");
        bus_write(4'h0, 2'd2, img(4, 1, 0, 0, 0));
        dbg_mode = 1'b0;
        tick(0, "R7 tick1");
        tick(0, "R7 tick2");
        tick(0, "R7 tick3");
        tick(1, "R7 loaded 4 expires");

        // R8 time-out zero behaves as one
        dbg_mode = 1'b1;
        bus_write(4'h0, 2'd2, img(0, 1, 0, 0, 0));
        service();
        dbg_mode = 1'b0;
        tick(1, "R8 zero time-out first tick");
        tick(1, "R8 zero time-out again");

        repeat (3) @(negedge clk);
        done = 1'b1;
        chk(exp_q.size() == 0, "R8 all requests seen", exp_q.size(), 32'h0);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule